// File: doc/BRIEF.md
# Misaligned Bus Transfer Splitter

This block sits between a load/store unit and a 64-bit big-endian processor bus. It accepts one operand access at a time, with a byte address, a size of 1, 2, 4 or 8 bytes, a direction, and right-justified write data. Each access becomes one or two bus beats. Each beat carries an address whose three low bits pick the starting byte lane, a four-bit byte-count size code, and an eight-bit lane enable vector.

An access that stays inside one 32-bit-aligned word is issued as a single beat, even when it is misaligned. An aligned 8-byte access is also a single beat. An access that runs past a word boundary is split into two beats at that boundary, and the leading part of the operand goes out first. Write operand bytes are steered onto the lanes in big-endian order. Read lanes from each beat are gathered into one right-justified result, which is presented with a completion pulse.

The requester side uses a request/ready handshake. Each bus beat is held until the bus acknowledges it. An 8-byte request that is not 8-byte aligned is refused with an error pulse.

Top module: `bus_split_unit`

## Requirements
- R1: `req_size` selects the operand length: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. Each beat's `beat_tsiz` is a zero MSB followed by the low three bits of that beat's byte count: 1 byte is 0001, 2 bytes is 0010, 3 bytes is 0011, 4 bytes is 0100 and 8 bytes is 0000.
- R2: `beat_addr[2:0]` is the first active lane of the beat. Lane k occupies `beat_wdata`/`beat_rdata` bits [63-8k : 56-8k], so lane 0 is the most significant byte. Bit k of `beat_be` is set exactly when lane k is active, and the active lanes are consecutive.
- R3: An access that fits inside one 32-bit-aligned word, or an 8-byte access at an 8-byte-aligned address, produces exactly one beat at the request address, covering all of its bytes.
- R4: An access of 4 bytes or fewer that crosses a 32-bit word boundary produces exactly two beats. The first beat starts at the request address and runs to the end of its word. The second beat starts at the next word boundary and carries the remaining bytes. For example, 4 bytes at word offset 1 split as 3+1, at offset 2 as 2+2, and at offset 3 as 1+3.
- R5: On writes, operand byte 0 is the most significant byte of the operand. Operand bytes fill consecutive lanes from the first active lane, continuing across both beats, and inactive lanes of `beat_wdata` are zero.
- R6: On reads, the bytes on each beat's active lanes are merged into `rdata`, right-justified. The first beat supplies the most significant bytes, bits above the operand length are zero, and inactive lanes have no effect.
- R7: `done` pulses for one cycle, in the cycle after the final beat is acknowledged. `rdata` holds the merged read operand during that cycle.
- R8: An 8-byte request whose address has a nonzero `addr[2:0]` is accepted, produces no beat, and raises `err` for one cycle in the cycle after acceptance. `done` does not pulse for it.
- R9: `req_ready` is high only while no beat is pending. While `beat_valid` is high and `beat_ack` is low, the beat outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_addr | input | 32 | Byte address of the operand |
| req_size | input | 2 | Operand length code |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 64 | Right-justified write operand |
| beat_valid | output | 1 | Bus beat presented |
| beat_ack | input | 1 | Bus accepts the current beat |
| beat_addr | output | 32 | Beat address, low bits give the first lane |
| beat_tsiz | output | 4 | Beat byte-count code |
| beat_be | output | 8 | Active lanes, bit k for lane k |
| beat_write | output | 1 | Beat direction |
| beat_wdata | output | 64 | Lane-steered write data |
| beat_rdata | input | 64 | Lane data returned with the acknowledge |
| done | output | 1 | Access complete pulse |
| rdata | output | 64 | Merged right-justified read operand |
| err | output | 1 | Misaligned 8-byte request refused |

## Verification
The bench sweeps every size at all eight lane offsets, for both reads and writes. The boundary offsets are the points where an implementation that splits on the double-word edge instead of the word edge would emit one beat where two are needed, or place the second beat at the wrong lane. A 2-byte access at offset 7 also checks that the second beat wraps to lane 0 of the next double-word. Read responses fill inactive lanes with foreign bytes, so a gather that ignores the enables corrupts `rdata`. A merge that reverses the beat order swaps the high and low parts of the operand. Misaligned 8-byte requests check that no beat escapes and that `done` stays low.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } bsu_state_e;
endpackage

// File: rtl/bsu_plan.sv
// Computes the lane window of the current beat from the operand offset and length.
module bsu_plan #(
  parameter int unsigned LANES      = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned LW = $clog2(LANES),
  localparam int unsigned CW = LW + 1,
  localparam int unsigned WL = $clog2(WORD_BYTES)
) (
  input  logic [LW-1:0] off,
  input  logic [CW-1:0] nbytes,
  input  logic          second,
  output logic [LW-1:0] lane,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] opidx,
  output logic          split
);
  localparam logic [CW-1:0] WB_C = CW'(WORD_BYTES);

  logic [CW-1:0] woff;
  logic [CW-1:0] head_cnt;
  logic [LW-1:0] next_word;

  always_comb begin
    woff      = {{(CW-WL){1'b0}}, off[WL-1:0]};
    head_cnt  = WB_C - woff;
    split     = (nbytes <= WB_C) && ((woff + nbytes) > WB_C);
    next_word = {off[LW-1:WL], {WL{1'b0}}} + LW'(WORD_BYTES);
    if (second) begin
      lane  = next_word;
      cnt   = nbytes - head_cnt;
      opidx = head_cnt;
    end else begin
      lane  = off;
      cnt   = split ? head_cnt : nbytes;
      opidx = '0;
    end
  end
endmodule

// File: rtl/bsu_lane.sv
// Steers write bytes onto lanes and gathers read lanes into the operand.
module bsu_lane #(
  parameter int unsigned LANES = 8,
  localparam int unsigned LW = $clog2(LANES),
  localparam int unsigned CW = LW + 1,
  localparam int unsigned DW = LANES * 8
) (
  input  logic [LW-1:0] lane,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] opidx,
  input  logic [CW-1:0] nbytes,
  input  logic [DW-1:0] opw,
  input  logic [DW-1:0] rdat,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] wlanes,
  output logic [LANES-1:0] be,
  output logic [DW-1:0] acc_o
);
  logic [CW-1:0] lane_c;
  assign lane_c = {1'b0, lane};

  for (genvar k = 0; k < LANES; k++) begin : g_wlane
    logic [CW-1:0] idx;
    logic [CW-1:0] pos;
    logic          act;
    always_comb begin
      act = (CW'(k) >= lane_c) && (CW'(k) < (lane_c + cnt));
      idx = CW'(k) - lane_c + opidx;
      pos = nbytes - CW'(1) - idx;
      be[k] = act;
      wlanes[DW-1-8*k -: 8] = act ? opw[{pos[LW-1:0], 3'b000} +: 8] : 8'h00;
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_gather
    logic [CW-1:0] idx;
    logic [LW-1:0] src;
    logic          hit;
    always_comb begin
      idx = nbytes - CW'(1) - CW'(p);
      hit = (CW'(p) < nbytes) && (idx >= opidx) && (idx < (opidx + cnt));
      src = lane + LW'(idx - opidx);
      acc_o[8*p +: 8] = hit ? rdat[{~src, 3'b000} +: 8] : acc_i[8*p +: 8];
    end
  end
endmodule

// File: rtl/bus_split_unit.sv
module bus_split_unit
  import bsu_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LANES      = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned LW = $clog2(LANES),
  localparam int unsigned CW = LW + 1,
  localparam int unsigned DW = LANES * 8,
  localparam int unsigned WL = $clog2(WORD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic             beat_valid,
  input  logic             beat_ack,
  output logic [AW-1:0]    beat_addr,
  output logic [3:0]       beat_tsiz,
  output logic [LANES-1:0] beat_be,
  output logic             beat_write,
  output logic [DW-1:0]    beat_wdata,
  input  logic [DW-1:0]    beat_rdata,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             err
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  bsu_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] nbytes_q, req_nbytes;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] acc_q, acc_d, acc_gather;
  logic          done_d, done_q, err_d, err_q;
  logic          accept, bad_dw, load_en, acc_en;

  logic [LW-1:0] p_lane;
  logic [CW-1:0] p_cnt, p_opidx;
  logic          p_split, second;

  assign req_nbytes = CW'(1) << req_size;
  assign bad_dw     = (req_size == 2'd3) && (req_addr[LW-1:0] != '0);
  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign load_en    = accept && !bad_dw;
  assign second     = (state_q == ST_SECOND);

  bsu_plan #(.LANES(LANES), .WORD_BYTES(WORD_BYTES)) u_plan (
    .off    (addr_q[LW-1:0]),
    .nbytes (nbytes_q),
    .second (second),
    .lane   (p_lane),
    .cnt    (p_cnt),
    .opidx  (p_opidx),
    .split  (p_split)
  );

  bsu_lane #(.LANES(LANES)) u_lane (
    .lane   (p_lane),
    .cnt    (p_cnt),
    .opidx  (p_opidx),
    .nbytes (nbytes_q),
    .opw    (wdata_q),
    .rdat   (beat_rdata),
    .acc_i  (acc_q),
    .wlanes (beat_wdata),
    .be     (beat_be),
    .acc_o  (acc_gather)
  );

  assign beat_valid = (state_q != ST_IDLE);
  assign beat_write = write_q;
  assign beat_tsiz  = {1'b0, p_cnt[2:0]};
  assign beat_addr  = second
                    ? ({addr_q[AW-1:WL], {WL{1'b0}}} + AW'(WORD_BYTES))
                    : addr_q;
  assign done  = done_q;
  assign err   = err_q;
  assign rdata = acc_q;

  // next-state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = accept && bad_dw;
    acc_en  = 1'b0;
    acc_d   = acc_q;
    case (state_q)
      ST_IDLE: begin
        if (load_en) begin
          state_d = ST_FIRST;
          acc_en  = 1'b1;
          acc_d   = '0;
        end
      end
      ST_FIRST: begin
        if (beat_ack) begin
          acc_en  = !write_q;
          acc_d   = acc_gather;
          state_d = p_split ? ST_SECOND : ST_IDLE;
          done_d  = !p_split;
        end
      end
      ST_SECOND: begin
        if (beat_ack) begin
          acc_en  = !write_q;
          acc_d   = acc_gather;
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      addr_q   <= '0;
      nbytes_q <= CW'(1);
      write_q  <= 1'b0;
      wdata_q  <= '0;
    end else if (load_en) begin
      addr_q   <= req_addr;
      nbytes_q <= req_nbytes;
      write_q  <= req_write;
      wdata_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  // assertions
  AST_SIZE_CODE_MATCHES_BE: assert property (@(posedge clk) disable iff (!rst_q)
    beat_valid |-> ($countones(beat_be) == ((beat_tsiz == 4'd0) ? LANES : int'(beat_tsiz)))); // R1
  AST_FIRST_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rst_q)
    beat_valid |-> beat_be[beat_addr[LW-1:0]]); // R2
  AST_NO_WORD_CROSS: assert property (@(posedge clk) disable iff (!rst_q)
    (beat_valid && beat_tsiz != 4'd0) |-> ((beat_addr[WL-1:0] + beat_tsiz[2:0]) <= 3'(WORD_BYTES))); // R4
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(done) |-> $past(beat_valid && beat_ack)); // R7
  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_q)
    err |-> (!beat_valid && !done)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_q)
    beat_valid |-> !req_ready); // R9
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    (beat_valid && !beat_ack) |=> (beat_valid && $stable(beat_addr) && $stable(beat_tsiz)
                                   && $stable(beat_be) && $stable(beat_wdata))); // R9
endmodule

// File: tb/bus_split_unit_tb.sv
module bus_split_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        beat_valid;
  logic        beat_ack = 1'b0;
  logic [31:0] beat_addr;
  logic [3:0]  beat_tsiz;
  logic [7:0]  beat_be;
  logic        beat_write;
  logic [63:0] beat_wdata;
  logic [63:0] beat_rdata = '0;
  logic        done;
  logic [63:0] rdata;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [31:0] addr; logic [3:0] tsiz; logic [7:0] be; logic [63:0] wdata; logic wr; } beat_t;
  typedef struct { logic is_err; logic [63:0] val; } res_t;
  beat_t exp_beats[$];
  res_t  exp_res[$];

  always #2 clk = ~clk;

  bus_split_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .beat_valid(beat_valid), .beat_ack(beat_ack), .beat_addr(beat_addr), .beat_tsiz(beat_tsiz),
    .beat_be(beat_be), .beat_write(beat_write), .beat_wdata(beat_wdata), .beat_rdata(beat_rdata),
    .done(done), .rdata(rdata), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  // Expected beat from the requirements: start address, byte count, first operand index.
  function automatic beat_t mk_beat(input logic [31:0] a, input int c, input int s,
                                    input int n, input logic [63:0] wd, input logic wr);
    beat_t b;
    b.addr = a;
    b.tsiz = (c == 8) ? 4'd0 : 4'(c);
    b.be = '0;
    b.wdata = '0;
    b.wr = wr;
    for (int j = 0; j < c; j++) begin
      int ln = int'(a[2:0]) + j;
      b.be[ln] = 1'b1;
      if (wr) b.wdata[63-8*ln -: 8] = wd[8*(n-1-s-j) +: 8];
    end
    return b;
  endfunction

  // Responder and beat scoreboard.
  int resp_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (beat_valid) begin
        for (int d = 0; d < resp_cnt % 3; d++) @(negedge clk);
        resp_cnt++;
        for (int k = 0; k < 8; k++) begin
          logic act;
          act = (k >= int'(beat_addr[2:0])) &&
                (k < int'(beat_addr[2:0]) + ((beat_tsiz == 0) ? 8 : int'(beat_tsiz)));
          beat_rdata[63-8*k -: 8] = act ? mem_byte({beat_addr[31:3], 3'b000} + 32'(k)) : (8'hE0 | 8'(k));
        end
        if (exp_beats.size() == 0) begin
          check(1'b0, "R3 unexpected beat", {32'h0, beat_addr}, 64'h0);
        end else begin
          beat_t e;
          e = exp_beats.pop_front();
          check(beat_addr == e.addr, "R4 beat address", {32'h0, beat_addr}, {32'h0, e.addr});
          check(beat_tsiz == e.tsiz, "R1 size code", {60'h0, beat_tsiz}, {60'h0, e.tsiz});
          check(beat_be == e.be, "R2 lane enables", {56'h0, beat_be}, {56'h0, e.be});
          check(beat_write == e.wr, "R5 beat direction", {63'h0, beat_write}, {63'h0, e.wr});
          if (e.wr) check(beat_wdata == e.wdata, "R5 lane data", beat_wdata, e.wdata);
        end
        beat_ack = 1'b1;
        @(negedge clk);
        beat_ack = 1'b0;
        beat_rdata = '1;
      end
    end
  end

  // Result monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (done || err) begin
        if (exp_res.size() == 0) begin
          check(1'b0, "R7 unexpected completion", {62'h0, done, err}, 64'h0);
        end else begin
          res_t r;
          r = exp_res.pop_front();
          check(err == r.is_err, "R8 error pulse", {63'h0, err}, {63'h0, r.is_err});
          check(done == !r.is_err, "R7 done pulse", {63'h0, done}, {63'h0, !r.is_err});
          if (!r.is_err && r.val !== 64'hx) check(rdata == r.val, "R6 merged read", rdata, r.val);
        end
      end
    end
  end

  task automatic do_req(input logic [31:0] a, input int sz, input logic wr, input logic [63:0] wd);
    int n = 1 << sz;
    int wo = int'(a[1:0]);
    res_t r;
    bit busy_ok = 1'b1;
    bit finished = 1'b0;
    logic [63:0] opw = wd;
    if (n < 8) opw = wd & ((64'h1 << (8*n)) - 64'h1);
    r.is_err = (sz == 3) && (a[2:0] != 3'd0);
    r.val = '0;
    if (wr) r.val = 64'hx;
    else for (int i = 0; i < n; i++) r.val[8*(n-1-i) +: 8] = mem_byte(a + 32'(i));
    if (!r.is_err) begin
      if (n <= 4 && wo + n > 4) begin
        exp_beats.push_back(mk_beat(a, 4 - wo, 0, n, opw, wr));
        exp_beats.push_back(mk_beat({a[31:2], 2'b00} + 32'd4, n - (4 - wo), 4 - wo, n, opw, wr));
      end else begin
        exp_beats.push_back(mk_beat(a, n, 0, n, opw, wr));
      end
    end
    exp_res.push_back(r);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = 2'(sz); req_write = wr; req_wdata = opw;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = '1; req_addr = '1;
    while (!finished) begin
      if (done || err) finished = 1'b1;
      else begin
        if (beat_valid && req_ready) busy_ok = 1'b0;
        @(negedge clk);
      end
    end
    check(busy_ok, "R9 ready low while beat pending", 64'h0, 64'h0);
    check(exp_beats.size() == 0, "R3 beat count", 64'(exp_beats.size()), 64'h0);
    exp_beats.delete();
    if (r.is_err) begin
      @(negedge clk);
      check(!beat_valid, "R8 no beat after refusal", {63'h0, beat_valid}, 64'h0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !beat_valid && !done && !err, "R9 reset state",
          {60'h0, req_ready, beat_valid, done, err}, 64'h8);
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 8; off++) begin
        do_req(32'h1000_0040 + 32'(off), sz, 1'b0, 64'h0);
        do_req(32'h2000_0080 + 32'(off), sz, 1'b1, 64'h1122_3344_5566_7788 ^ 64'(off * 16'h0F0F));
      end
    do_req(32'h3000_0008, 3, 1'b0, 64'h0);
    do_req(32'h3000_0010, 3, 1'b1, 64'h0102_0304_0506_0708);
    do_req(32'h3000_0003, 3, 1'b0, 64'h0);
    do_req(32'h3000_0004, 3, 1'b1, 64'hDEAD_BEEF_0000_0001);
    do_req(32'h3000_0017, 1, 1'b0, 64'h0);
    repeat (4) @(negedge clk);
    check(exp_res.size() == 0, "R7 all completions seen", 64'(exp_res.size()), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'h1, 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule